// File: doc/BRIEF.md
# Counted Pulse Stimulus Generator

This block drives four stimulus pins for an analog measurement front end from a single ADC clock. A phase counter divides the clock into cycles of 16 clocks, or 8 in the fast setting. In each cycle the raw pulse is high during the first half of the cycle and low during the second half. The pulse stream is either a counted burst, started by writing a nonzero count to the configuration register, or a continuous stream that runs for as long as at least one pin is enabled.

Each pin has its own enable bit and its own polarity bit. A disabled pin rests at its inactive level, which is 0, or 1 when its polarity bit is set. The phase counter can also run on its own, without pulses, whenever the ADC is enabled. Software uses a small word-addressed register port with a configuration register and a control register. The control register also has set and clear aliases, so single bits can be changed without a read-modify-write.

Top module: `stim_pulse_gen`

## Requirements
- R1: A synchronous reset clears every register and the burst state. After reset all pins read 0, `status` is 0, `phase_pos` is 0, and both registers read 0.
- R2: The configuration register is at byte offset 0x00. Bits 11:0 hold the pulse count, bit 12 selects the fast cycle, bit 13 enables phase free-run and bit 14 enables pulse free-run. Bits 31:15 read 0.
- R3: The control register is at offset 0x10. Bits 3:0 are the per-pin invert bits and bits 7:4 are the per-pin enables, with pin i using bit i and bit 4+i. Bit 8 reads as `status`, and writes to it are ignored. Writing to offset 0x14 sets the control bits written as 1. Writing to offset 0x18 clears them. All three offsets read the same value.
- R4: The cycle is 16 clocks long when bit 12 is 0 and 8 clocks long when it is 1. While running, `phase_pos` counts 0 to length-1 and then wraps to 0.
- R5: The raw pulse is high while `phase_pos` is below half the cycle length, and low otherwise.
- R6: A configuration write with a nonzero count and bit 14 clear starts a burst from phase 0. The burst lasts exactly that many cycles and then goes idle. A configuration write with a count of 0 ends any burst that is running.
- R7: With pulse free-run set, pulses continue whatever the count is, for as long as any enable is 1. They stop in the cycle after all four enables become 0.
- R8: With phase free-run clear, `phase_pos` stays 0 when no pulses are being produced. With it set and `adc_en` high, `phase_pos` counts even when there are no pulses.
- R9: `pulse_out[i]` equals (raw pulse AND enable i) XOR invert i. A disabled pin therefore sits at its invert value.
- R10: `status` is 1 exactly while pulses are being generated, either as a burst or in free-run. When `status` is 0, `pulse_out` equals the invert bits.
- R11: Writes to any other offset change nothing, and reads from any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_en | input | 1 | ADC enabled; lets the phase counter free-run |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| pulse_out | output | 4 | Stimulus pins |
| status | output | 1 | Pulse generator active |
| phase_pos | output | 4 | Current position within the cycle |

## Verification
The assertions check four things on every cycle. A disabled pin always sits at its invert level, and all pins show their invert levels whenever `status` is low. The phase position never goes past the fast cycle length, and it only advances by one or returns to zero. A burst can only end on the last phase of a cycle, unless a configuration write cut it short. The bench scenarios are needed to show the rest. They show that a burst produces exactly the programmed number of pulses, and that free-run stops when the last enable is cleared. They show that phase free-run follows `adc_en`. They show that the set and clear aliases, the read-only status bit and unmapped offsets behave as specified.

// File: rtl/stim_pkg.sv
package stim_pkg;
    localparam int NUM_OUT = 4;
    localparam int CNT_W   = 12;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int CTL_W   = 2 * NUM_OUT;

    localparam logic [ADDR_W-1:0] OFS_CFG = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SET = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_CLR = 5'h18;

    localparam int BIT_PUFR = CNT_W + 2;

    // packed MSB first: pulse free-run, phase free-run, fast select, count
    typedef struct packed {
        logic             pu_fr;
        logic             ph_fr;
        logic             fast;
        logic [CNT_W-1:0] count;
    } cfg_t;

    typedef struct packed {
        logic [NUM_OUT-1:0] en;
        logic [NUM_OUT-1:0] inv;
    } ctl_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/stim_regs.sv
module stim_regs
    import stim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              status,
    output cfg_t              cfg,
    output ctl_t              ctl,
    output logic              cfg_wr,
    output logic              load_go,
    output logic [CNT_W-1:0]  load_cnt,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        cfg_t cfg;
        ctl_t ctl;
    } regs_t;

    regs_t            r_d, r_q;
    logic [CTL_W-1:0] wr_ctl;
    logic             unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CFG_W];
    assign load_cnt  = wr_data[CNT_W-1:0];

    always_comb begin
        r_d     = r_q;
        cfg_wr  = 1'b0;
        load_go = 1'b0;
        wr_ctl  = wr_data[CTL_W-1:0];
        if (wr_en) begin
            case (wr_addr)
                OFS_CFG: begin
                    r_d.cfg = wr_data[CFG_W-1:0];
                    cfg_wr  = 1'b1;
                    load_go = (wr_data[CNT_W-1:0] != '0) && !wr_data[BIT_PUFR];
                end
                OFS_CTL: r_d.ctl = wr_ctl;
                OFS_SET: r_d.ctl = r_q.ctl | wr_ctl;
                OFS_CLR: r_d.ctl = r_q.ctl & ~wr_ctl;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_CFG:                   rd_data[CFG_W-1:0] = r_q.cfg;
            OFS_CTL, OFS_SET, OFS_CLR: rd_data[CTL_W:0]   = {status, r_q.ctl};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign cfg = r_q.cfg;
    assign ctl = r_q.ctl;
endmodule

// File: rtl/stim_phase.sv
module stim_phase #(
    parameter int LONG_LEN  = 16,
    parameter int SHORT_LEN = 8,
    localparam int PH_W     = $clog2(LONG_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic            fast,
    output logic [PH_W-1:0] phase,
    output logic            cyc_end,
    output logic            first_half
);
    localparam logic [PH_W-1:0] LAST_LONG  = PH_W'(LONG_LEN - 1);
    localparam logic [PH_W-1:0] LAST_SHORT = PH_W'(SHORT_LEN - 1);
    localparam logic [PH_W-1:0] HALF_LONG  = PH_W'(LONG_LEN / 2);
    localparam logic [PH_W-1:0] HALF_SHORT = PH_W'(SHORT_LEN / 2);

    logic [PH_W-1:0] ph_d, ph_q;
    logic [PH_W-1:0] last, half;
    logic            wrap;

    always_comb begin
        last       = fast ? LAST_SHORT : LAST_LONG;
        half       = fast ? HALF_SHORT : HALF_LONG;
        wrap       = (ph_q >= last);
        cyc_end    = run && wrap;
        first_half = (ph_q < half);
        if (restart || !run) ph_d = '0;
        else if (wrap)       ph_d = '0;
        else                 ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_d;
    end

    assign phase = ph_q;
endmodule

// File: rtl/stim_burst.sv
module stim_burst
    import stim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_go,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             cyc_end,
    output logic             busy
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
    } bst_t;

    bst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.busy = load_go;
            s_d.left = load_cnt;
        end else if (s_q.busy && cyc_end) begin
            s_d.left = s_q.left - 1'b1;
            if (s_q.left == CNT_W'(1)) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy = s_q.busy;
endmodule

// File: rtl/stim_drive.sv
module stim_drive #(
    parameter int N = 4
) (
    input  logic         raw,
    input  logic [N-1:0] en,
    input  logic [N-1:0] inv,
    output logic [N-1:0] pins
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pins[i] = (raw & en[i]) ^ inv[i];
    end
endmodule

// File: rtl/stim_pulse_gen.sv
module stim_pulse_gen
    import stim_pkg::*;
#(
    parameter int LONG_LEN  = 16,
    parameter int SHORT_LEN = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        adc_en,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_OUT-1:0]          pulse_out,
    output logic                        status,
    output logic [$clog2(LONG_LEN)-1:0] phase_pos
);
    cfg_t             cfg;
    ctl_t             ctl;
    logic             cfg_wr, load_go, busy;
    logic [CNT_W-1:0] load_cnt;
    logic             pulse_run, phase_run, cyc_end, first_half, raw;
    logic [NUM_OUT-1:0] en_vec, inv_vec;
    logic             fast_sel;

    assign en_vec    = ctl.en;
    assign inv_vec   = ctl.inv;
    assign fast_sel  = cfg.fast;
    assign pulse_run = busy | (cfg.pu_fr & (|ctl.en));
    assign phase_run = pulse_run | (cfg.ph_fr & adc_en);
    assign raw       = pulse_run & first_half;
    assign status    = pulse_run;

    stim_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .status(pulse_run), .cfg(cfg), .ctl(ctl), .cfg_wr(cfg_wr),
        .load_go(load_go), .load_cnt(load_cnt), .rd_data(rd_data)
    );

    stim_phase #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_phase (
        .clk(clk), .rst(rst), .run(phase_run), .restart(cfg_wr), .fast(cfg.fast),
        .phase(phase_pos), .cyc_end(cyc_end), .first_half(first_half)
    );

    stim_burst u_burst (
        .clk(clk), .rst(rst), .load(cfg_wr), .load_go(load_go), .load_cnt(load_cnt),
        .cyc_end(cyc_end), .busy(busy)
    );

    stim_drive #(.N(NUM_OUT)) u_drive (
        .raw(raw), .en(ctl.en), .inv(ctl.inv), .pins(pulse_out)
    );
endmodule

// File: rtl/stim_checks.sv
module stim_checks #(
    parameter int N         = 4,
    parameter int LONG_LEN  = 16,
    parameter int SHORT_LEN = 8,
    localparam int PH_W     = $clog2(LONG_LEN)
) (
    input logic            clk,
    input logic            rst,
    input logic            fast,
    input logic            cfg_wr,
    input logic            busy,
    input logic            status,
    input logic [N-1:0]    en,
    input logic [N-1:0]    inv,
    input logic [N-1:0]    pins,
    input logic [PH_W-1:0] phase_pos
);
    AST_DISABLED_AT_REST: assert property (@(posedge clk) disable iff (rst)
        (pins & ~en) == (inv & ~en)); // R9

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !status |-> (pins == inv)); // R10

    AST_FAST_RANGE: assert property (@(posedge clk) disable iff (rst)
        fast |-> (32'(phase_pos) < SHORT_LEN)); // R4

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr && phase_pos != '0) |=>
            (phase_pos == PH_W'($past(phase_pos) + 1'b1)) || (phase_pos == '0)); // R4

    AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cfg_wr)) |->
            (32'($past(phase_pos)) == (fast ? SHORT_LEN - 1 : LONG_LEN - 1))); // R6
endmodule

bind stim_pulse_gen stim_checks #(.N(stim_pkg::NUM_OUT), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_chk (
    .clk(clk), .rst(rst), .fast(fast_sel), .cfg_wr(cfg_wr), .busy(busy), .status(status),
    .en(en_vec), .inv(inv_vec), .pins(pulse_out), .phase_pos(phase_pos)
);

// File: tb/sim_stim_pulse_gen.sv
module sim_stim_pulse_gen;
    import stim_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int PHW = 4;

    logic clk = 1'b0, rst = 1'b1, adc_en = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_OUT-1:0] pulse_out;
    logic status;
    logic [PHW-1:0] phase_pos;

    int n_chk = 0, n_bad = 0, cyc = 0, rises = 0;
    logic prev1 = 1'b0;
    int m_count, m_fast, m_phfr, m_pufr, m_inv, m_en, m_busy, m_left, m_phase;

    stim_pulse_gen u0 (
        .clk(clk), .rst(rst), .adc_en(adc_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pulse_out(pulse_out), .status(status), .phase_pos(phase_pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int m_run();
        return (m_busy != 0 || (m_pufr != 0 && m_en != 0)) ? 1 : 0;
    endfunction
    function automatic int m_len();
        return (m_fast != 0) ? 8 : 16;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int run, len, wrap, ph;
        cyc++;
        if (rst) begin
            m_count = 0; m_fast = 0; m_phfr = 0; m_pufr = 0; m_inv = 0; m_en = 0;
            m_busy = 0; m_left = 0; m_phase = 0;
        end else begin
            run  = m_run();
            len  = m_len();
            ph   = (run != 0 || (m_phfr != 0 && adc_en)) ? 1 : 0;
            wrap = (m_phase >= len - 1) ? 1 : 0;
            if (ph != 0) m_phase = (wrap != 0) ? 0 : m_phase + 1;
            else         m_phase = 0;
            if (m_busy != 0 && wrap != 0) begin
                m_left--;
                if (m_left == 0) m_busy = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    5'h00: begin
                        m_count = int'(wr_data[11:0]);
                        m_fast  = int'(wr_data[12]);
                        m_phfr  = int'(wr_data[13]);
                        m_pufr  = int'(wr_data[14]);
                        m_busy  = (m_count != 0 && m_pufr == 0) ? 1 : 0;
                        m_left  = m_count;
                        m_phase = 0;
                    end
                    5'h10: begin m_inv = int'(wr_data[3:0]); m_en = int'(wr_data[7:4]); end
                    5'h14: begin m_inv |= int'(wr_data[3:0]); m_en |= int'(wr_data[7:4]); end
                    5'h18: begin m_inv &= ~int'(wr_data[3:0]); m_en &= ~int'(wr_data[7:4]); end
                    default: ;
                endcase
            end
        end
    end

    // rotate the read offset across all mapped and one unmapped address
    always @(posedge clk) begin
        #1;
        case (cyc % 5)
            0: rd_addr = 5'h00;
            1: rd_addr = 5'h10;
            2: rd_addr = 5'h14;
            3: rd_addr = 5'h18;
            default: rd_addr = 5'h08;
        endcase
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [3:0] e_out;
        logic [31:0] e_rd;
        int run, len;
        if (!rst) begin
            run = m_run();
            len = m_len();
            for (int i = 0; i < 4; i++)
                e_out[i] = ((run != 0 && m_phase < len / 2 && m_en[i]) ? 1'b1 : 1'b0) ^ m_inv[i];
            chk("R9 pulse_out", 32'(pulse_out), 32'(e_out));
            chk("R10 status", 32'(status), 32'(run));
            chk("R4 phase_pos", 32'(phase_pos), 32'(m_phase));
            e_rd = '0;
            case (rd_addr)
                5'h00: e_rd = 32'((m_pufr << 14) | (m_phfr << 13) | (m_fast << 12) | m_count);
                5'h10, 5'h14, 5'h18: e_rd = 32'((run << 8) | (m_en << 4) | m_inv);
                default: e_rd = '0;
            endcase
            if (rd_addr == 5'h00)      chk("R2 cfg read", rd_data, e_rd);
            else if (rd_addr == 5'h08) chk("R11 unmapped read", rd_data, e_rd);
            else                       chk("R3 ctl read", rd_data, e_rd);
            if (pulse_out[1] && !prev1) rises++;
            prev1 = pulse_out[1];
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk);
        chk("R1 reset pins", 32'(pulse_out), 32'h0);
        chk("R1 reset status", 32'(status), 32'h0);
        chk("R1 reset phase", 32'(phase_pos), 32'h0);
        @(posedge clk); #1; rst = 1'b0;

        // counted burst, long cycle, all pins enabled via the set alias
        wr(5'h14, 32'hF0);
        rises = 0;
        wr(5'h00, 32'd3);
        idle(60);
        @(negedge clk);
        chk("R6 burst of three pulses", 32'(rises), 32'd3);
        chk("R6 idle after burst", 32'(status), 32'h0);

        // short cycle, mixed enables and inverts
        wr(5'h18, 32'hF0);
        wr(5'h10, 32'h35);
        rises = 0;
        wr(5'h00, 32'h1002);
        idle(25);
        @(negedge clk);
        chk("R4 R5 short burst of two pulses", 32'(rises), 32'd2);
        chk("R9 idle pins at invert level", 32'(pulse_out), 32'h5);

        // count of zero aborts a burst
        wr(5'h00, 32'd10);
        idle(5);
        wr(5'h00, 32'd0);
        @(negedge clk);
        chk("R6 abort with zero count", 32'(status), 32'h0);

        // pulse free-run, then disable all pins
        wr(5'h10, 32'hF0);
        rises = 0;
        wr(5'h00, 32'h4000);
        idle(40);
        @(negedge clk);
        chk("R7 free-run active", 32'(status), 32'h1);
        chk("R7 free-run keeps pulsing", 32'(rises >= 2), 32'h1);
        wr(5'h18, 32'hF0);
        @(negedge clk);
        chk("R7 stops when all pins off", 32'(status), 32'h0);

        // phase free-run gated by adc_en
        wr(5'h00, 32'h2000);
        @(posedge clk); #1; adc_en = 1'b1;
        idle(5);
        @(negedge clk);
        chk("R8 phase runs with adc on", 32'(phase_pos != 0), 32'h1);
        @(posedge clk); #1; adc_en = 1'b0;
        idle(2);
        @(negedge clk);
        chk("R8 phase parks with adc off", 32'(phase_pos), 32'h0);
        wr(5'h00, 32'h0);
        @(posedge clk); #1; adc_en = 1'b1;
        idle(5);
        @(negedge clk);
        chk("R8 no free-run without enable bit", 32'(phase_pos), 32'h0);
        @(posedge clk); #1; adc_en = 1'b0;

        // status bit is read-only
        wr(5'h10, 32'h1F0);
        @(negedge clk);
        chk("R3 status write ignored", 32'(status), 32'h0);

        // unmapped write changes nothing
        wr(5'h08, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R11 unmapped write ignored", 32'(status), 32'h0);
        idle(6);

        // reset in the middle of a burst
        wr(5'h00, 32'd5);
        idle(10);
        @(posedge clk); #1; rst = 1'b1;
        idle(1);
        @(negedge clk);
        chk("R1 reset stops burst", 32'(status), 32'h0);
        chk("R1 reset clears pins", 32'(pulse_out), 32'h0);
        @(posedge clk); #1; rst = 1'b0;
        idle(5);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule